// File: doc/BRIEF.md
# Power-Management Event Root Status Register

This block holds the power-management event (PME) status seen by software at a PCIe root port. Each incoming PME carries a 16-bit requester ID. The first event to arrive while the status bit is clear is shown at once. Events that arrive while one is already shown wait in a small first-in first-out queue.

Software reads one 32-bit register. Writing 1 to the status bit acknowledges the event that is shown. If other events are waiting, hardware reloads the register with the oldest waiting event in the same clock edge as the clear, so the status bit stays set. A pending flag, managed by hardware alone, tells software whether more events wait behind the one shown. When the queue is full, a repeat of a requester ID that is already queued is dropped silently. Any other new event raises a one-cycle overflow pulse and is lost.

Top module: `pme_root_status`

## Requirements
- R1: After reset the register reads all zeros. It answers at offset 0x0C0 only, and bits 31:18 always read 0.
- R2: While bit 16 (status) is 0, a PME with valid high sets bit 16 and loads its requester ID into bits 15:0. Both are visible the cycle after the strobe.
- R3: Writing 1 to bit 16 at offset 0x0C0 clears the status when no event waits. Writing 0 to bit 16 leaves it unchanged. Writes to bits 17 and 15:0 have no effect.
- R4: A PME that arrives while bit 16 is 1 leaves bits 15:0 unchanged and joins the queue of waiting events.
- R5: Bit 17 (pending) reads 1 exactly when at least one event waits in the queue.
- R6: A clear issued while events wait keeps bit 16 at 1 and loads bits 15:0 with the oldest waiting ID in the next cycle. Waiting events are presented in arrival order.
- R7: A PME in the same cycle as a clear is handled after the clear. If the queue is empty, the new ID is shown in the next cycle. Otherwise the queue head is shown and the new ID joins the tail.
- R8: With the queue full (4 entries by default), a PME whose ID equals a queued ID is discarded without an overflow pulse.
- R9: With the queue full, a PME with an ID not in the queue is discarded, and pme_overflow is high for exactly the next cycle.
- R10: Writes to any other offset change nothing, and reads at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 12 | Configuration register offset |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| pme_valid | input | 1 | PME arrival strobe |
| pme_rid | input | 16 | Requester ID of the arriving PME |
| pme_overflow | output | 1 | One-cycle pulse when an event is lost to a full queue |

## Verification
The bench builds the block with its default parameters: a queue depth of 4 and a 16-bit requester ID. The shallow queue lets a short directed sequence fill it. That reaches the duplicate-drop and overflow cases, and a clear combined with a PME while the queue is full. A pseudo-random phase draws IDs from a small set, so duplicates often meet a full queue, and simultaneous clear and PME cycles occur often. A behavioural queue model checks the register and the overflow pulse on every cycle.

// File: rtl/pme_root_status.sv
module pme_root_status #(
  parameter int          ID_W    = 16,
  parameter int          DEPTH   = 4,
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] REG_OFS = 12'h0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              pme_valid,
  input  logic [ID_W-1:0]   pme_rid,
  output logic              pme_overflow
);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PAD = 32 - ID_W - 2;

  logic              stat_q;
  logic [ID_W-1:0]   id_q;
  logic [ID_W-1:0]   q_mem [DEPTH];
  logic [PW-1:0]     rd_q;
  logic [CW-1:0]     cnt_q;
  logic              ovf_q;

  wire hit   = (cfg_addr == ADDR_W'(REG_OFS));
  wire clr   = cfg_wr & hit & cfg_wdata[ID_W] & stat_q;
  wire full  = (cnt_q == CW'(DEPTH));
  wire empty = (cnt_q == '0);

  logic [DEPTH-1:0] dup_v;
  for (genvar i = 0; i < DEPTH; i++) begin : g_dup
    assign dup_v[i] = (q_mem[i] == pme_rid);
  end
  wire dup = |dup_v;

  wire [PW:0]   wsum   = {1'b0, rd_q} + (PW+1)'(cnt_q);
  wire [PW:0]   wwrap  = (wsum >= (PW+1)'(DEPTH)) ? wsum - (PW+1)'(DEPTH) : wsum;
  wire [PW-1:0] wr_idx = wwrap[PW-1:0];
  wire [PW-1:0] rd_nxt = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;

  wire do_pop   = clr & ~empty;
  wire do_push  = pme_valid & stat_q & (clr ? ~empty : ~full);
  wire load_new = pme_valid & (~stat_q | (clr & empty));
  wire ovf_n    = pme_valid & stat_q & ~clr & full & ~dup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      id_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) q_mem[i] <= '0;
    end else begin
      ovf_q <= ovf_n;
      if (do_pop || load_new) stat_q <= 1'b1;
      else if (clr)           stat_q <= 1'b0;
      if (do_pop)             id_q <= q_mem[rd_q];
      else if (load_new)      id_q <= pme_rid;
      if (do_push)            q_mem[wr_idx] <= pme_rid;
      if (do_pop)             rd_q <= rd_nxt;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign cfg_rdata    = hit ? {{PAD{1'b0}}, ~empty, stat_q, id_q} : 32'h0;
  assign pme_overflow = ovf_q;
endmodule

module pme_root_status_chk #(
  parameter int          ID_W    = 16,
  parameter int          DEPTH   = 4,
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] REG_OFS = 12'h0C0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_wr,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic              pme_valid,
  input logic [ID_W-1:0]   pme_rid,
  input logic              pme_overflow,
  input logic              stat_q,
  input logic [ID_W-1:0]   id_q,
  input logic [$clog2(DEPTH+1)-1:0] cnt_q
);
  wire hit = (cfg_addr == ADDR_W'(REG_OFS));
  wire clr = cfg_wr & hit & cfg_wdata[ID_W] & stat_q;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:ID_W+2] == '0);
  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> cfg_rdata == 32'h0);
  a_r2_set_on_pme: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q && pme_valid) |=> (stat_q && id_q == $past(pme_rid)));
  a_r4_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr) |=> (stat_q && $stable(id_q)));
  a_r5_pending_implies_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> stat_q);
  a_r6_refill_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && cnt_q != '0) |=> stat_q);
  a_r9_overflow_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    pme_overflow |-> ($past(cnt_q) == ($clog2(DEPTH+1))'(DEPTH) && $past(pme_valid)));
endmodule

bind pme_root_status pme_root_status_chk #(
  .ID_W(ID_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .REG_OFS(REG_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pme_valid(pme_valid),
  .pme_rid(pme_rid), .pme_overflow(pme_overflow), .stat_q(stat_q),
  .id_q(id_q), .cnt_q(cnt_q)
);

// File: tb/pme_root_status_tb.sv
module pme_root_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_addr = 12'h0C0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pme_valid = 1'b0;
  logic [15:0] pme_rid = '0;
  logic        pme_overflow;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  bit          m_stat = 0;
  logic [15:0] m_id = '0;
  logic [15:0] m_q[$];
  bit          m_ovf = 0;

  always #5 clk = ~clk;

  pme_root_status u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pme_valid(pme_valid),
    .pme_rid(pme_rid), .pme_overflow(pme_overflow)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_id = '0; m_q.delete(); m_ovf = 0;
    end else begin
      bit clr;
      bit found;
      m_ovf = 0;
      clr = cfg_wr && cfg_addr == 12'h0C0 && cfg_wdata[16] && m_stat;
      if (!m_stat) begin
        if (pme_valid) begin m_stat = 1; m_id = pme_rid; end
      end else if (clr) begin
        if (m_q.size() > 0) begin
          m_id = m_q.pop_front();
          if (pme_valid) m_q.push_back(pme_rid);
        end else if (pme_valid) m_id = pme_rid;
        else m_stat = 0;
      end else if (pme_valid) begin
        if (m_q.size() < 4) m_q.push_back(pme_rid);
        else begin
          found = 0;
          foreach (m_q[k]) if (m_q[k] == pme_rid) found = 1;
          if (!found) m_ovf = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] e;
    e = (cfg_addr == 12'h0C0) ? {14'b0, (m_q.size() != 0), m_stat, m_id} : 32'h0;
    if (cfg_addr != 12'h0C0) chk(cfg_rdata == e, "R10 read miss", cfg_rdata, e);
    else begin
      chk(cfg_rdata[31:18] == e[31:18], "R1 reserved bits", cfg_rdata, e);
      chk(cfg_rdata[17] == e[17], "R5 pending flag", cfg_rdata, e);
      chk(cfg_rdata[16] == e[16], "R3 status bit", cfg_rdata, e);
      chk(cfg_rdata[15:0] == e[15:0], "R4 requester id", cfg_rdata, e);
    end
    chk(pme_overflow == m_ovf, "R9 overflow pulse", {31'b0, pme_overflow}, {31'b0, m_ovf});
  endtask

  task automatic step(input logic [11:0] a, input bit w, input logic [31:0] d,
                      input bit pv, input logic [15:0] r);
    @(negedge clk);
    compare();
    cfg_addr = a; cfg_wr = w; cfg_wdata = d; pme_valid = pv; pme_rid = r;
  endtask

  task automatic expect_reg(input logic [31:0] exp, input string tag);
    @(negedge clk);
    compare();
    cfg_addr = 12'h0C0; cfg_wr = 0; cfg_wdata = '0; pme_valid = 0;
    #1;
    chk(cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic idle();
    step(12'h0C0, 0, 0, 0, 0);
  endtask

  localparam logic [31:0] CLR = 32'h0001_0000;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_reg(32'h0, "R1 reset value");
    // R2: first event shown
    step(12'h0C0, 0, 0, 1, 16'hAAAA);
    expect_reg(32'h0001_AAAA, "R2 first event");
    // R4 / R5: queued behind
    step(12'h0C0, 0, 0, 1, 16'hBBBB);
    step(12'h0C0, 0, 0, 1, 16'hCCCC);
    expect_reg(32'h0003_AAAA, "R4 id held, R5 pending set");
    // R3: write 0 to status and 1s to other fields ignored
    step(12'h0C0, 1, 32'hFFFE_FFFF, 0, 0);
    expect_reg(32'h0003_AAAA, "R3 write zero ignored");
    // R10: other address
    step(12'h0C4, 1, 32'hFFFF_FFFF, 0, 0);
    expect_reg(32'h0003_AAAA, "R10 other offset write");
    // R6: clears present in order
    step(12'h0C0, 1, CLR, 0, 0);
    expect_reg(32'h0003_BBBB, "R6 second event");
    step(12'h0C0, 1, CLR, 0, 0);
    expect_reg(32'h0001_CCCC, "R6 third event, R5 pending cleared");
    step(12'h0C0, 1, CLR, 0, 0);
    expect_reg(32'h0000_CCCC, "R3 status cleared");
    // R7: clear and PME together, empty queue
    step(12'h0C0, 0, 0, 1, 16'h1111);
    step(12'h0C0, 1, CLR, 1, 16'h2222);
    expect_reg(32'h0001_2222, "R7 new event after clear");
    // fill queue
    step(12'h0C0, 0, 0, 1, 16'h0001);
    step(12'h0C0, 0, 0, 1, 16'h0002);
    step(12'h0C0, 0, 0, 1, 16'h0003);
    step(12'h0C0, 0, 0, 1, 16'h0004);
    step(12'h0C0, 0, 0, 1, 16'h0003);
    @(negedge clk); #1;
    chk(pme_overflow == 0, "R8 duplicate dropped", {31'b0, pme_overflow}, 0);
    step(12'h0C0, 0, 0, 1, 16'h0009);
    @(negedge clk); #1;
    chk(pme_overflow == 1, "R9 overflow raised", {31'b0, pme_overflow}, 1);
    // R7: clear + PME with full queue
    step(12'h0C0, 1, CLR, 1, 16'h0005);
    expect_reg(32'h0003_0001, "R7 head shown on clear with PME");
    for (int i = 0; i < 4; i++) step(12'h0C0, 1, CLR, 0, 0);
    expect_reg(32'h0001_0005, "R7 new event queued at tail");
    step(12'h0C0, 1, CLR, 0, 0);
    idle();
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[9] ? 12'h0C0 : 12'h0C8, lf[3] & lf[5], {15'b0, lf[7], lf[15:0]},
           lf[0] | lf[1], {13'b0, lf[12:10] % 3'd6});
    end
    idle();
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule